// File: doc/BRIEF.md
# Dedicated Receive Buffer Lock Controller

This block guards a bank of up to 64 dedicated receive buffers in a message RAM. The acceptance-filter pipeline presents filter elements one at a time, in priority order. Each element arrives with a match indication, a 3-bit configuration code and an 11-bit second ID field. The block decides in the same cycle whether a match leads to a store into a dedicated buffer. If it does not, the block decides whether filtering goes on to the next element. For an accepted store it gives the buffer index and the buffer's word address in the RAM. The address is a configurable base plus four words per buffer.

Each buffer has a new-data flag. The RAM data path reports when the final word of a message has landed in a buffer. The block then sets that buffer's flag and raises a sticky interrupt for stored-in-dedicated-buffer events.

A buffer whose flag is set protects its contents. Any filter element aimed at that buffer is treated as a non-match, so filtering falls through to later elements. Those elements may store into another buffer or a FIFO, or they may reject the message. The host releases buffers by writing ones into the flag words, which are 32 bits wide. Writing zeros changes nothing.

Top module: `rxbuf_lock_ctrl`

## Requirements
- R1: After reset, every new-data flag is 0, the interrupt is 0, and with no evaluation presented both `accept_o` and `continue_o` are 0.
- R2: `accept_o` is 1 exactly when all of the following hold in that cycle: `eval_valid` is 1, `eval_match` is 1, `eval_cfg` is 3'b111, `eval_id2[10:9]` is 2'b00, and the targeted buffer's flag is 0.
- R3: `accept_idx_o` equals `eval_id2[5:0]`, the target buffer index.
- R4: `accept_addr_o` equals `start_addr + 4*eval_id2[5:0]`, taken modulo the address width.
- R5: A pulse on `store_done` with index n sets bit n of `ndat_o` from the next clock edge. Flag n is bit n%32 of host word n/32, where word 0 covers buffers 0..31 and word 1 covers buffers 32..63.
- R6: While buffer n's flag is 1, a valid dedicated-store element that targets n gives `accept_o`=0 and `continue_o`=1.
- R7: A valid element with `eval_match`=0 gives `continue_o`=1 and `accept_o`=0. A valid matching element that is not a dedicated store gives `continue_o`=0 and `accept_o`=0.
- R8: A host clear write selects word `clr_sel` and clears, at the next edge, each flag whose bit in `clr_data` is 1. Bits written as 0 are left unchanged.
- R9: If a host clear and a store completion hit the same flag in one cycle, the flag ends up 1.
- R10: The interrupt is set by every store completion and stays set until `irq_clr` is pulsed. If a store completion and a clear arrive in the same cycle, the interrupt stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_addr | input | 16 | Word address of buffer 0 |
| eval_valid | input | 1 | A filter element is being evaluated |
| eval_match | input | 1 | The element's ID comparison matched |
| eval_cfg | input | 3 | Element configuration code |
| eval_id2 | input | 11 | Second ID field of the element |
| store_done | input | 1 | Last word of a message written to a buffer |
| store_idx | input | 6 | Buffer that completed |
| clr_wr | input | 1 | Host write-one-to-clear on a flag word |
| clr_sel | input | 1 | Flag word selector |
| clr_data | input | 32 | Bits to clear |
| irq_clr | input | 1 | Host clears the interrupt |
| accept_o | output | 1 | Store into dedicated buffer goes ahead |
| accept_idx_o | output | 6 | Accepted buffer index |
| accept_addr_o | output | 16 | Accepted buffer word address |
| continue_o | output | 1 | Filtering moves on to the next element |
| ndat_o | output | 64 | New-data flags, one per buffer |
| irq_o | output | 1 | Stored-in-dedicated-buffer interrupt |

## Verification
Two pairs of operations can land on the same edge: a store completion and a host clear of the same flag bit, and a store completion and the interrupt clear. The bench raises `store_done` together with `clr_wr` for the matching bit, and separately together with `irq_clr`. In both cases it checks that the flag or the interrupt reads 1 at the next sample. It also checks that a clear on a different bit still takes effect in that same cycle.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
    localparam int IDX_W   = 6;
    localparam int WORD_W  = 32;
    localparam int ID2_W   = 11;
    localparam int CFG_W   = 3;
    localparam logic [CFG_W-1:0] CFG_STORE_DED = 3'b111;
    localparam logic [1:0]       TGT_DED       = 2'b00;

    typedef struct packed {
        logic             accept;
        logic             cont;
        logic [IDX_W-1:0] idx;
    } decision_t;
endpackage

// File: rtl/rxbuf_filter_decode.sv
module rxbuf_filter_decode
    import rxbuf_pkg::*;
#(
    parameter int NUM_BUFS = 64,
    parameter int ADDR_W   = 16
) (
    input  logic                eval_valid,
    input  logic                eval_match,
    input  logic [CFG_W-1:0]    eval_cfg,
    input  logic [ID2_W-1:0]    eval_id2,
    input  logic [NUM_BUFS-1:0] ndat_q,
    input  logic [ADDR_W-1:0]   start_addr,
    output decision_t           dec_o,
    output logic [ADDR_W-1:0]   addr_o
);
    localparam int PAD_W = 1 << IDX_W;

    logic [PAD_W-1:0] lock_pad;
    logic             is_ded;
    logic             locked;
    logic             eff_match;
    logic             unused_id_bits;

    assign unused_id_bits = ^eval_id2[8:IDX_W];

    always_comb begin
        // targets beyond the populated buffers read as locked
        lock_pad                 = '1;
        lock_pad[NUM_BUFS-1:0]   = ndat_q;
        dec_o.idx  = eval_id2[IDX_W-1:0];
        is_ded     = (eval_cfg == CFG_STORE_DED) && (eval_id2[10:9] == TGT_DED);
        locked     = is_ded && lock_pad[dec_o.idx];
        eff_match  = eval_match && !locked;
        dec_o.accept = eval_valid && eff_match && is_ded;
        dec_o.cont   = eval_valid && !eff_match;
        addr_o = start_addr + ADDR_W'({dec_o.idx, 2'b00});
    end
endmodule

// File: rtl/rxbuf_flag_bank.sv
module rxbuf_flag_bank
    import rxbuf_pkg::*;
#(
    parameter int NUM_BUFS = 64,
    parameter int SEL_W    = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_vld,
    input  logic [IDX_W-1:0]    set_idx,
    input  logic                clr_wr,
    input  logic [SEL_W-1:0]    clr_sel,
    input  logic [WORD_W-1:0]   clr_data,
    output logic [NUM_BUFS-1:0] ndat_q_o
);
    localparam int NUM_WORDS = (NUM_BUFS + WORD_W - 1) / WORD_W;
    localparam int PAD_W     = 1 << IDX_W;

    typedef struct packed {
        logic [NUM_BUFS-1:0] ndat;
    } flag_state_t;

    flag_state_t                  st_d, st_q;
    logic [NUM_WORDS*WORD_W-1:0]  clr_pad;
    logic [PAD_W-1:0]             set_pad;
    logic [NUM_BUFS-1:0]          clr_mask, set_mask;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        assign clr_pad[w*WORD_W +: WORD_W] =
            (clr_wr && (clr_sel == SEL_W'(w))) ? clr_data : '0;
    end

    always_comb begin
        set_pad  = set_vld ? (PAD_W'(1) << set_idx) : '0;
        set_mask = set_pad[NUM_BUFS-1:0];
        clr_mask = clr_pad[NUM_BUFS-1:0];
        st_d      = st_q;
        // hardware set takes priority over host clear
        st_d.ndat = (st_q.ndat & ~clr_mask) | set_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ndat_q_o = st_q.ndat;

    a_r5_set_visible: assert property (@(posedge clk) disable iff (!rst_n)
        set_vld |=> st_q.ndat[$past(set_idx)]);
    a_r5_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        !set_vld |=> ((st_q.ndat & ~$past(st_q.ndat)) == '0));
    a_r8_clear_only_masked: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(st_q.ndat) & ~st_q.ndat & ~$past(clr_mask)) == '0));
endmodule

// File: rtl/rxbuf_irq_flag.sv
module rxbuf_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_set,
    input  logic irq_clr,
    output logic irq_q_o
);
    typedef struct packed {
        logic irq;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (irq_set)      st_d.irq = 1'b1;
        else if (irq_clr) st_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_q_o = st_q.irq;

    a_r10_set_on_store: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> st_q.irq);
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && !irq_clr) |=> st_q.irq);
endmodule

// File: rtl/rxbuf_lock_ctrl.sv
module rxbuf_lock_ctrl
    import rxbuf_pkg::*;
#(
    parameter int NUM_BUFS = 64,
    parameter int ADDR_W   = 16,
    localparam int NUM_WORDS = (NUM_BUFS + WORD_W - 1) / WORD_W,
    localparam int SEL_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   start_addr,
    input  logic                eval_valid,
    input  logic                eval_match,
    input  logic [CFG_W-1:0]    eval_cfg,
    input  logic [ID2_W-1:0]    eval_id2,
    input  logic                store_done,
    input  logic [IDX_W-1:0]    store_idx,
    input  logic                clr_wr,
    input  logic [SEL_W-1:0]    clr_sel,
    input  logic [WORD_W-1:0]   clr_data,
    input  logic                irq_clr,
    output logic                accept_o,
    output logic [IDX_W-1:0]    accept_idx_o,
    output logic [ADDR_W-1:0]   accept_addr_o,
    output logic                continue_o,
    output logic [NUM_BUFS-1:0] ndat_o,
    output logic                irq_o
);
    decision_t dec;

    rxbuf_filter_decode #(.NUM_BUFS(NUM_BUFS), .ADDR_W(ADDR_W)) decode_i (
        .eval_valid (eval_valid),
        .eval_match (eval_match),
        .eval_cfg   (eval_cfg),
        .eval_id2   (eval_id2),
        .ndat_q     (ndat_o),
        .start_addr (start_addr),
        .dec_o      (dec),
        .addr_o     (accept_addr_o)
    );

    rxbuf_flag_bank #(.NUM_BUFS(NUM_BUFS), .SEL_W(SEL_W)) flags_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vld  (store_done),
        .set_idx  (store_idx),
        .clr_wr   (clr_wr),
        .clr_sel  (clr_sel),
        .clr_data (clr_data),
        .ndat_q_o (ndat_o)
    );

    rxbuf_irq_flag irq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_set (store_done),
        .irq_clr (irq_clr),
        .irq_q_o (irq_o)
    );

    assign accept_o     = dec.accept;
    assign continue_o   = dec.cont;
    assign accept_idx_o = dec.idx;

    a_r2_accept_needs_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> !ndat_o[accept_idx_o]);
    a_r6_locked_falls_through: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_valid && eval_match && eval_cfg == CFG_STORE_DED &&
         eval_id2[10:9] == TGT_DED && ndat_o[eval_id2[IDX_W-1:0]])
        |-> (!accept_o && continue_o));
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept_o && continue_o));
endmodule

// File: tb/rxbuf_lock_ctrl_tb_top.sv
module rxbuf_lock_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] start_addr;
    logic        eval_valid, eval_match;
    logic [2:0]  eval_cfg;
    logic [10:0] eval_id2;
    logic        store_done;
    logic [5:0]  store_idx;
    logic        clr_wr;
    logic [0:0]  clr_sel;
    logic [31:0] clr_data;
    logic        irq_clr;
    logic        accept_o, continue_o, irq_o;
    logic [5:0]  accept_idx_o;
    logic [15:0] accept_addr_o;
    logic [63:0] ndat_o;

    int checks = 0;
    int failures = 0;
    logic [63:0] exp_flags;
    logic        exp_irq;

    always #5 clk = ~clk;

    rxbuf_lock_ctrl dut_i (.*);

    task automatic chk(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        eval_valid = 0; eval_match = 0; eval_cfg = 0; eval_id2 = 0;
        store_done = 0; store_idx = 0; clr_wr = 0; clr_sel = 0;
        clr_data = 0; irq_clr = 0;
    endtask

    task automatic present_ded(input int idx);
        eval_valid = 1; eval_match = 1; eval_cfg = 3'b111;
        eval_id2 = {2'b00, 3'b000, 6'(idx)};
        #1;
    endtask

    task automatic step();
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        start_addr = 16'h0400;
        exp_flags = '0;
        exp_irq = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk(ndat_o == 0, "R1 flags", ndat_o, 0);
        chk(irq_o == 0, "R1 irq", 64'(irq_o), 0);
        chk(!accept_o && !continue_o, "R1 idle outputs",
            64'({accept_o, continue_o}), 0);

        // R2/R7 sweep of config code and target kind
        for (int c = 0; c < 8; c++) begin
            for (int t = 0; t < 4; t++) begin
                @(negedge clk);
                eval_valid = 1; eval_match = 1; eval_cfg = 3'(c);
                eval_id2 = {2'(t), 3'b000, 6'd5};
                #1;
                chk(accept_o == (c == 7 && t == 0), "R2 cfg sweep accept",
                    64'(accept_o), 64'(c == 7 && t == 0));
                chk(continue_o == 0, "R7 matching element stops filtering",
                    64'(continue_o), 0);
                eval_match = 0;
                #1;
                chk(continue_o && !accept_o, "R7 non-match continues",
                    64'({accept_o, continue_o}), 64'b01);
                idle();
            end
        end

        // R3/R4/R5/R6 sweep of every buffer
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            present_ded(i);
            chk(accept_o && !continue_o, "R2 unlocked accept",
                64'({accept_o, continue_o}), 64'b10);
            chk(accept_idx_o == 6'(i), "R3 index", 64'(accept_idx_o), 64'(i));
            chk(accept_addr_o == 16'(16'h0400 + 4 * i), "R4 address",
                64'(accept_addr_o), 64'(16'h0400 + 4 * i));
            idle();
            store_done = 1; store_idx = 6'(i);
            step();
            exp_flags[i] = 1'b1;
            exp_irq = 1'b1;
            #1;
            chk(ndat_o == exp_flags, "R5 flag set", ndat_o, exp_flags);
            chk(irq_o == exp_irq, "R10 irq on store", 64'(irq_o), 64'(exp_irq));
            present_ded(i);
            chk(!accept_o && continue_o, "R6 locked falls through",
                64'({accept_o, continue_o}), 64'b01);
            if (i < 63) begin
                present_ded(i + 1);
                chk(accept_o, "R6 neighbour unlocked", 64'(accept_o), 1);
            end
            idle();
            if (i % 8 == 7) begin
                @(negedge clk);
                irq_clr = 1;
                step();
                exp_irq = 0;
                #1;
                chk(irq_o == 0, "R10 irq clear", 64'(irq_o), 0);
            end
        end

        // R8 write-one-to-clear
        @(negedge clk);
        clr_wr = 1; clr_sel = 0; clr_data = 32'h0;
        step(); #1;
        chk(ndat_o == exp_flags, "R8 zero write no effect", ndat_o, exp_flags);
        @(negedge clk);
        clr_wr = 1; clr_sel = 1; clr_data = 32'hA5A5_0001;
        step(); #1;
        exp_flags[63:32] = exp_flags[63:32] & ~32'hA5A5_0001;
        chk(ndat_o == exp_flags, "R8 clear upper word", ndat_o, exp_flags);
        @(negedge clk);
        clr_wr = 1; clr_sel = 0; clr_data = 32'hFFFF_FFFF;
        step(); #1;
        exp_flags[31:0] = '0;
        chk(ndat_o == exp_flags, "R8 clear lower word", ndat_o, exp_flags);
        present_ded(32);
        chk(accept_o, "R8 released buffer accepts", 64'(accept_o), 1);
        present_ded(33);
        chk(!accept_o && continue_o, "R6 still locked after partial clear",
            64'({accept_o, continue_o}), 64'b01);
        idle();

        // R9 collision: set and clear of same bit, plus clear of another bit
        @(negedge clk);
        store_done = 1; store_idx = 6'd3;
        clr_wr = 1; clr_sel = 1; clr_data = 32'h0000_0002; // clears bit 33
        step(); #1;
        exp_flags[3] = 1'b1;
        exp_flags[33] = 1'b0;
        chk(ndat_o == exp_flags, "R9 set vs other clear", ndat_o, exp_flags);
        @(negedge clk);
        store_done = 1; store_idx = 6'd3;
        clr_wr = 1; clr_sel = 0; clr_data = 32'h0000_0008;
        step(); #1;
        chk(ndat_o[3] == 1'b1, "R9 set wins same bit", 64'(ndat_o[3]), 1);

        // R10 collision of store and interrupt clear
        @(negedge clk);
        irq_clr = 1;
        step(); #1;
        chk(irq_o == 0, "R10 irq cleared", 64'(irq_o), 0);
        @(negedge clk);
        store_done = 1; store_idx = 6'd10; irq_clr = 1;
        step(); #1;
        chk(irq_o == 1, "R10 set wins over clear", 64'(irq_o), 1);
        @(negedge clk); #1;
        chk(irq_o == 1, "R10 sticky", 64'(irq_o), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule